// File: doc/BRIEF.md
# Debug Event Status and Interrupt Controller

This block sits between a processor's debug event sources and its interrupt logic. Each cycle it takes a vector of single-cycle event pulses and decides which of them are recorded as sticky bits in a status word. The decision depends on three things: whether software-visible (internal) debug is switched on, whether an external debugger has taken over, and the per-event enable bits. One event input, the unconditional one, needs no enable bit. Software reads the status word at any time. It cannot write the word directly and can only clear bits, through a write-one-to-clear port.

The machine-state debug-interrupt enable splits the events into two classes. While it is low, a suppressible event is dropped completely. An always-record event is still latched, and an imprecise flag in the status word is set alongside it. A latched bit raises the debug interrupt request as soon as the enable goes high. The request is a level. Two fields never contribute to it: the 2-bit reset-record field, captured from an input on the first clock after reset, and the status bit of the counter-trigger event. The imprecise flag does not contribute either.

Top module: `dbgev_status_top`

## Requirements
- R1: While reset is asserted, `stat_q` is all zeros and `dbg_irq` is 0.
- R2: An event pulse can set its status bit (bit `EVT_LSB+i` for input `i`) only in a cycle where `intdbg_en`=1 and `extdbg_on`=0. In any other cycle no event bit and no imprecise flag is set.
- R3: Event `i` is recorded only if `evt_en[i]`=1. The exception is event `UNCOND_EVT`, which is recorded whatever its enable bit holds.
- R4: When `dbg_int_en`=0, an event whose `KEEP_MASK` bit is 0 sets no status bit. An event whose `KEEP_MASK` bit is 1 is still recorded.
- R5: Whenever at least one event is recorded while `dbg_int_en`=0, status bit `IMPR_POS` is also set in the same update. It is never set in any other way.
- R6: `dbg_irq` = `dbg_int_en` AND (any set event status bit other than the one of event `CTRIG_EVT`). The two reset-record bits `RREC_LSB+1:RREC_LSB` and the flag at `IMPR_POS` never assert it. `dbg_irq` follows `stat_q` and `dbg_int_en` with no extra delay and stays asserted as long as both conditions hold.
- R7: A bit latched while `dbg_int_en`=0 asserts `dbg_irq` as soon as `dbg_int_en` becomes 1. This also holds when `intdbg_en` and `dbg_int_en` are raised in the same cycle.
- R8: A clock edge with `clr_we`=1 clears exactly the status bits where `clr_data` holds a 1 and leaves every other bit unchanged. No other write path exists.
- R9: If an event and a clear hit the same status bit at the same edge, the bit ends up set.
- R10: At the first clock edge after reset is released, bits `RREC_LSB+1:RREC_LSB` take the value of `rst_cause`. After that, only the clear port changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | N_EVT | One-cycle debug event pulses, one per event source |
| evt_en | input | N_EVT | Per-event enable bits |
| intdbg_en | input | 1 | Software-visible (internal) debug mode on |
| extdbg_on | input | 1 | External debugger in control; overrides internal mode |
| dbg_int_en | input | 1 | Machine-state debug-interrupt enable |
| rst_cause | input | 2 | Reset-kind code captured into the reset-record field after reset |
| clr_we | input | 1 | Write strobe for the write-one-to-clear port |
| clr_data | input | STAT_W | Bits to clear; a 1 clears the matching status bit |
| stat_q | output | STAT_W | Status word read port |
| dbg_irq | output | 1 | Level debug interrupt request |

## Verification
The bench builds the block with a 16-bit status word, six event inputs at bits 5:0, unconditional event 0, counter-trigger event 5, `KEEP_MASK`=6'b101010 (events 1, 3 and 5 always recorded), reset-record field at bits 13:12 and the imprecise flag at bit 15. With only six events, every event pattern can be crossed with all eight combinations of the three mode inputs and with three enable patterns. That puts the suppressed and the always-record class, both excluded fields and the unconditional override under direct comparison against an arithmetic model. Directed sequences cover the delayed request, the request raised by enabling both modes at once, partial clears and a clear colliding with an event.

// File: rtl/dbgev_pkg.sv
package dbgev_pkg;

   typedef enum logic {
      CLS_SUPPRESS = 1'b0,
      CLS_KEEP     = 1'b1
   } evt_class_t;

   typedef struct packed {
      logic sw_on;    // internal mode on, not overridden
      logic masked;   // interrupt enable low, no external debugger
   } dbg_mode_t;

   localparam int RREC_W = 2;

   function automatic logic [63:0] bit_span(input int lsb, input int n);
      logic [63:0] m;
      m = (n >= 64) ? {64{1'b1}} : ((64'd1 << n) - 64'd1);
      return m << lsb;
   endfunction

endpackage

// File: rtl/dbgev_qualify.sv
module dbgev_qualify
   import dbgev_pkg::*;
#(
   parameter int             N_EVT      = 12,
   parameter int             UNCOND_EVT = 0,
   parameter logic [N_EVT-1:0] KEEP_MASK = '0
)(
   input  logic [N_EVT-1:0] evt_pulse,
   input  logic [N_EVT-1:0] evt_en,
   input  logic             intdbg_en,
   input  logic             extdbg_on,
   input  logic             dbg_int_en,
   output logic [N_EVT-1:0] rec,
   output logic             rec_masked
);

   dbg_mode_t mode;

   assign mode.sw_on  = intdbg_en & ~extdbg_on;
   assign mode.masked = ~dbg_int_en & ~extdbg_on;

   for (genvar i = 0; i < N_EVT; i++) begin : g_evt
      localparam evt_class_t CLS = evt_class_t'(KEEP_MASK[i]);
      logic armed;

      if (i == UNCOND_EVT) begin : g_uncond
         assign armed = 1'b1;
      end else begin : g_cond
         assign armed = evt_en[i];
      end

      if (CLS == CLS_KEEP) begin : g_keep
         assign rec[i] = evt_pulse[i] & mode.sw_on & armed;
      end else begin : g_supp
         assign rec[i] = evt_pulse[i] & mode.sw_on & armed & ~mode.masked;
      end
   end

   assign rec_masked = mode.masked & (|rec);

endmodule

// File: rtl/dbgev_statreg.sv
module dbgev_statreg
   import dbgev_pkg::*;
#(
   parameter int STAT_W   = 32,
   parameter int N_EVT    = 12,
   parameter int EVT_LSB  = 4,
   parameter int IMPR_POS = 0,
   parameter int RREC_LSB = 28
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EVT-1:0]  rec,
   input  logic              rec_masked,
   input  logic [RREC_W-1:0] rst_cause,
   input  logic              clr_we,
   input  logic [STAT_W-1:0] clr_data,
   output logic [STAT_W-1:0] stat_q
);

   logic [STAT_W-1:0] set_v;
   logic [STAT_W-1:0] clr_v;
   logic [STAT_W-1:0] stat_d;
   logic              cap_pend;

   always_comb begin
      set_v = '0;
      for (int i = 0; i < N_EVT; i++) begin
         set_v[EVT_LSB + i] = rec[i];
      end
      if (rec_masked) begin
         set_v[IMPR_POS] = 1'b1;
      end
      if (cap_pend) begin
         set_v[RREC_LSB +: RREC_W] = rst_cause;
      end
   end

   assign clr_v  = clr_we ? clr_data : '0;
   // new recordings take priority over a same-edge clear
   assign stat_d = (stat_q & ~clr_v) | set_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q   <= '0;
         cap_pend <= 1'b1;
      end else begin
         stat_q   <= stat_d;
         cap_pend <= 1'b0;
      end
   end

endmodule

// File: rtl/dbgev_irqgen.sv
module dbgev_irqgen #(
   parameter int                STAT_W  = 32,
   parameter logic [STAT_W-1:0] CONTRIB = '0
)(
   input  logic [STAT_W-1:0] stat_q,
   input  logic              dbg_int_en,
   output logic              dbg_irq
);

   logic any_pending;

   assign any_pending = |(stat_q & CONTRIB);
   assign dbg_irq     = dbg_int_en & any_pending;

endmodule

// File: rtl/dbgev_status_top.sv
module dbgev_status_top
   import dbgev_pkg::*;
#(
   parameter int STAT_W     = 32,
   parameter int N_EVT      = 12,
   parameter int EVT_LSB    = 4,
   parameter int IMPR_POS   = 0,
   parameter int RREC_LSB   = 28,
   parameter int UNCOND_EVT = 0,
   parameter int CTRIG_EVT  = 11,
   parameter logic [N_EVT-1:0] KEEP_MASK = 12'hF00
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EVT-1:0]  evt_pulse,
   input  logic [N_EVT-1:0]  evt_en,
   input  logic              intdbg_en,
   input  logic              extdbg_on,
   input  logic              dbg_int_en,
   input  logic [1:0]        rst_cause,
   input  logic              clr_we,
   input  logic [STAT_W-1:0] clr_data,
   output logic [STAT_W-1:0] stat_q,
   output logic              dbg_irq
);

   localparam logic [STAT_W-1:0] EVT_FIELD =
      STAT_W'(bit_span(EVT_LSB, N_EVT));
   localparam logic [STAT_W-1:0] CTRIG_BIT =
      STAT_W'(bit_span(EVT_LSB + CTRIG_EVT, 1));
   localparam logic [STAT_W-1:0] CONTRIB = EVT_FIELD & ~CTRIG_BIT;

   // elaboration-time parameter checks
   if (STAT_W < 8 || STAT_W > 64) begin : g_bad_width
      $error("dbgev_status_top: STAT_W must lie in 8..64");
   end
   if (N_EVT < 1 || EVT_LSB < 0 || EVT_LSB + N_EVT > STAT_W) begin : g_bad_evt
      $error("dbgev_status_top: event field does not fit the status word");
   end
   if (IMPR_POS < 0 || IMPR_POS >= STAT_W ||
       (IMPR_POS >= EVT_LSB && IMPR_POS < EVT_LSB + N_EVT)) begin : g_bad_impr
      $error("dbgev_status_top: imprecise flag position invalid");
   end
   if (RREC_LSB < 0 || RREC_LSB + RREC_W > STAT_W ||
       (RREC_LSB + RREC_W > EVT_LSB && RREC_LSB < EVT_LSB + N_EVT) ||
       (IMPR_POS >= RREC_LSB && IMPR_POS < RREC_LSB + RREC_W)) begin : g_bad_rrec
      $error("dbgev_status_top: reset-record field overlaps another field");
   end
   if (UNCOND_EVT < 0 || UNCOND_EVT >= N_EVT ||
       CTRIG_EVT < 0 || CTRIG_EVT >= N_EVT) begin : g_bad_idx
      $error("dbgev_status_top: special event index out of range");
   end

   logic [N_EVT-1:0] rec;
   logic             rec_masked;

   dbgev_qualify #(
      .N_EVT      (N_EVT),
      .UNCOND_EVT (UNCOND_EVT),
      .KEEP_MASK  (KEEP_MASK)
   ) u_qual (
      .evt_pulse  (evt_pulse),
      .evt_en     (evt_en),
      .intdbg_en  (intdbg_en),
      .extdbg_on  (extdbg_on),
      .dbg_int_en (dbg_int_en),
      .rec        (rec),
      .rec_masked (rec_masked)
   );

   dbgev_statreg #(
      .STAT_W   (STAT_W),
      .N_EVT    (N_EVT),
      .EVT_LSB  (EVT_LSB),
      .IMPR_POS (IMPR_POS),
      .RREC_LSB (RREC_LSB)
   ) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .rec        (rec),
      .rec_masked (rec_masked),
      .rst_cause  (rst_cause),
      .clr_we     (clr_we),
      .clr_data   (clr_data),
      .stat_q     (stat_q)
   );

   dbgev_irqgen #(
      .STAT_W  (STAT_W),
      .CONTRIB (CONTRIB)
   ) u_irq (
      .stat_q     (stat_q),
      .dbg_int_en (dbg_int_en),
      .dbg_irq    (dbg_irq)
   );

endmodule

// File: rtl/dbgev_status_chk.sv
module dbgev_status_chk
   import dbgev_pkg::*;
#(
   parameter int STAT_W    = 32,
   parameter int N_EVT     = 12,
   parameter int EVT_LSB   = 4,
   parameter int IMPR_POS  = 0,
   parameter int RREC_LSB  = 28,
   parameter int CTRIG_EVT = 11
)(
   input logic              clk,
   input logic              rst_n,
   input logic [N_EVT-1:0]  evt_pulse,
   input logic              intdbg_en,
   input logic              extdbg_on,
   input logic              dbg_int_en,
   input logic              clr_we,
   input logic [STAT_W-1:0] clr_data,
   input logic [STAT_W-1:0] stat_q,
   input logic              dbg_irq
);

   localparam logic [STAT_W-1:0] EVTS  = STAT_W'(bit_span(EVT_LSB, N_EVT));
   localparam logic [STAT_W-1:0] RREC  = STAT_W'(bit_span(RREC_LSB, RREC_W));
   localparam logic [STAT_W-1:0] CTRIG = STAT_W'(bit_span(EVT_LSB + CTRIG_EVT, 1));
   localparam logic [STAT_W-1:0] LIVE  = EVTS & ~CTRIG;

   // R1: reset holds the status word at zero
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (stat_q == '0));

   // R2: no new event bit when software debug is off or overridden
   a_r2_no_record_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!intdbg_en || extdbg_on) |=> ((stat_q & ~$past(stat_q) & EVTS) == '0));

   // R5: imprecise flag rises only after an event seen with interrupts masked
   a_r5_impr_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[IMPR_POS]) |-> $past(!dbg_int_en && !extdbg_on && (|evt_pulse)));

   // R6: request needs the enable
   a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_irq |-> dbg_int_en);

   // R6: excluded fields alone never request
   a_r6_excluded_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & LIVE) == '0) |-> !dbg_irq);

   // R8: a clear with no events leaves no targeted bit set
   a_r8_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && evt_pulse == '0) |=> ((stat_q & $past(clr_data) & ~RREC) == '0));

   // R8: without a clear no bit ever falls
   a_r8_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> (($past(stat_q) & ~stat_q) == '0));

endmodule

bind dbgev_status_top dbgev_status_chk #(
   .STAT_W    (STAT_W),
   .N_EVT     (N_EVT),
   .EVT_LSB   (EVT_LSB),
   .IMPR_POS  (IMPR_POS),
   .RREC_LSB  (RREC_LSB),
   .CTRIG_EVT (CTRIG_EVT)
) u_chk (.*);

// File: tb/test_dbgev_status_top.sv
`timescale 1ns/1ps
module test_dbgev_status_top;

   localparam int SW = 16;
   localparam int NE = 6;
   localparam logic [NE-1:0] KEEP = 6'b101010;
   localparam logic [SW-1:0] LIVE_E = 16'h001F;  // events 0..4; 5 is counter trigger

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] evt_pulse = '0;
   logic [NE-1:0] evt_en = '0;
   logic          intdbg_en = 1'b0;
   logic          extdbg_on = 1'b0;
   logic          dbg_int_en = 1'b0;
   logic [1:0]    rst_cause = 2'b10;
   logic          clr_we = 1'b0;
   logic [SW-1:0] clr_data = '0;
   logic [SW-1:0] stat_q;
   logic          dbg_irq;

   int vecs = 0;
   int bad = 0;
   logic [SW-1:0] exp_stat = '0;
   logic          cap_first = 1'b1;

   always #4 clk = ~clk;   // 125 MHz

   dbgev_status_top #(
      .STAT_W(SW), .N_EVT(NE), .EVT_LSB(0), .IMPR_POS(15), .RREC_LSB(12),
      .UNCOND_EVT(0), .CTRIG_EVT(5), .KEEP_MASK(KEEP)
   ) i_dbgev_status_top (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_en(evt_en),
      .intdbg_en(intdbg_en), .extdbg_on(extdbg_on), .dbg_int_en(dbg_int_en),
      .rst_cause(rst_cause), .clr_we(clr_we), .clr_data(clr_data),
      .stat_q(stat_q), .dbg_irq(dbg_irq)
   );

   task automatic check(input string tag);
      logic exp_irq;
      exp_irq = dbg_int_en & (|(exp_stat & LIVE_E));
      vecs++;
      if (stat_q !== exp_stat) begin
         bad++;
         $display("FAIL %s stat_q=%h expected %h", tag, stat_q, exp_stat);
      end
      vecs++;
      if (dbg_irq !== exp_irq) begin
         bad++;
         $display("FAIL %s dbg_irq=%b expected %b (stat %h)", tag, dbg_irq, exp_irq, exp_stat);
      end
   endtask

   // drive at negedge, model at posedge, compare at the next negedge
   task automatic step(input logic [NE-1:0] p, input logic [NE-1:0] en,
                       input logic idm, input logic edm, input logic de,
                       input logic we, input logic [SW-1:0] wd, input string tag);
      logic [SW-1:0] setv;
      evt_pulse = p; evt_en = en; intdbg_en = idm; extdbg_on = edm;
      dbg_int_en = de; clr_we = we; clr_data = wd;
      @(posedge clk);
      setv = '0;
      for (int i = 0; i < NE; i++) begin
         if (p[i] && idm && !edm && (en[i] || i == 0) && (de || KEEP[i]))
            setv[i] = 1'b1;
      end
      if ((|setv[NE-1:0]) && !de) setv[15] = 1'b1;
      if (cap_first) begin
         setv[13:12] = rst_cause;
         cap_first = 1'b0;
      end
      exp_stat = (exp_stat & ~(we ? wd : '0)) | setv;
      @(negedge clk);
      check(tag);
      evt_pulse = '0;
      clr_we = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset");
      rst_n = 1'b1;
      // first edge after release captures rst_cause (2'b10 -> bit 13); R6 excluded
      step('0, '0, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R10 R6 capture");
      step('0, '0, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R10 hold");
      // counter-trigger event bit 5 alone gives no request
      step(6'h20, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R6 counter trigger");
      step('0, '0, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFF, "R8 clear all");

      // sweep: mode x event pattern x enable pattern
      for (int m = 0; m < 8; m++) begin
         for (int e = 0; e < 3; e++) begin
            for (int p = 0; p < 64; p++) begin
               logic [NE-1:0] enp;
               enp = (e == 0) ? 6'h3F : (e == 1) ? 6'h00 : 6'h15;
               step('0, enp, m[0], m[1], m[2], 1'b1, 16'hFFFF, "R8 sweep clear");
               step(6'(p), enp, m[0], m[1], m[2], 1'b0, '0, "R2 R3 R4 R5 sweep");
            end
         end
      end

      // partial clear
      step('0, '0, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFF, "R8 clear");
      step(6'h1F, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R6 set many");
      step('0, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0005, "R8 partial clear");
      step('0, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFE0, "R8 clear unset bits");
      // collision: event 2 and clear-all at the same edge
      step(6'h04, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFF, "R9 event wins");
      step('0, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFF, "R8 clear");
      // delayed request
      step(6'h02, 6'h3F, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R4 R5 masked keep");
      step('0, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R7 delayed request");
      step('0, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R6 level held");
      step('0, 6'h3F, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R6 enable dropped");
      step('0, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R7 both raised");
      step('0, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0002, "R6 impr alone quiet");
      step('0, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b1, 16'h8000, "R8 clear impr");

      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

endmodule